// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Alignment and E-bit Tracker

This block finds the 16-frame CRC-4 multiframe on a received E1 stream once basic frame alignment exists. The framer upstream presents one value per frame: a strobe, a flag that says whether the frame is a non-alignment (odd) frame, the bit carried in position 1 of timeslot 0, the received remote alarm (A) bit and a flag that says basic frame alignment is lost. From the odd-frame bits the block finds the six-bit multiframe word `001011`. It then counts frames 0 to 15 and reads the two remote error bits from their fixed frames.

The block runs a three-state machine. HUNT shifts the bit of every odd frame into a six-bit window. When the window holds the word, it takes that frame as frame 11 and moves to CONFIRM (transition *word found*). In CONFIRM the frame counter runs. At the next frame 11 a second good word moves the machine to LOCKED (*word confirmed*). A missing word sends it back to HUNT (*confirm failed*). LOCKED holds until basic alignment is lost. The *alignment lost* transition takes any state to HUNT.

While LOCKED, the block reads the remote error bits, checks for the remote CRC/alarm condition once per multiframe, and marks each multiframe end with a pulse.

Top module: `crc4_mf_tracker`

## Requirements
- R1: After reset, `mfa_lost`=1, `e1_stat`=1, `e2_stat`=1, `rem_crc_rai`=0 and `mf_end`=0.
- R2: Odd frames are the non-alignment frames. The word `001011` is read MSB first from the odd frames 1, 3, 5, 7, 9 and 11. One word alone leaves `mfa_lost`=1. A second word exactly 16 frames later clears `mfa_lost` on the clock edge that samples the strobe of that frame 11. It then stays 0 until `bfa_lost` rises.
- R3: If the word is missing at frame 11 of the confirming multiframe, the search starts over. Two more good words one multiframe apart are then needed before `mfa_lost` clears.
- R4: `bfa_lost`=1 makes `mfa_lost`=1 at once and drops sync. Sync comes back only after two good words once `bfa_lost` is 0 again.
- R5: `e1_stat` holds the bit of frame 13 and `e2_stat` holds the bit of frame 15. Each updates on the edge that samples that frame's strobe. A value of 0 means the far end counted a CRC-4 error in that sub-multiframe.
- R6: While `mfa_lost`=1, `e1_stat` and `e2_stat` both read 1, whatever bits are received.
- R7: `rem_crc_rai` takes the value A AND (NOT E1 OR NOT E2). A and E2 are sampled with the frame-15 strobe, and E1 is the frame-13 bit of the same multiframe. The value holds for the whole next multiframe. It reads 0 while `mfa_lost`=1.
- R8: While locked, `mf_end` is high for exactly the one clock after the edge that samples the frame-15 strobe, and low at every other time.
- R9: After frame 15 the frame count wraps to 0, so later multiframes keep the same frame numbering with no new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe per received frame; the other inputs are valid with it |
| nfas_phase | input | 1 | 1 when the strobed frame is a non-alignment (odd) frame |
| ts0_b1 | input | 1 | Bit position 1 of timeslot 0 of the strobed frame |
| rai_a | input | 1 | Received remote alarm (A) bit |
| bfa_lost | input | 1 | 1 while basic frame alignment is lost |
| mfa_lost | output | 1 | 1 while CRC-4 multiframe alignment is not held |
| e1_stat | output | 1 | Remote error bit from frame 13 (forced to 1 when unsynced) |
| e2_stat | output | 1 | Remote error bit from frame 15 (forced to 1 when unsynced) |
| rem_crc_rai | output | 1 | Remote alarm together with a remote CRC error, updated once per multiframe |
| mf_end | output | 1 | One-cycle pulse at the end of frame 15 |

## Verification
`mfa_lost` follows `bfa_lost` in the same cycle. In every other case it changes on the edge that samples the strobe of the deciding frame 11. `e1_stat`, `e2_stat`, `rem_crc_rai` and `mf_end` change on the edge that samples the strobe of frame 13 or frame 15. The bench drives each frame on a falling edge, keeps the strobe high for one cycle, and reads every output on the next falling edge, one register stage after the sampling edge. It then idles for one cycle before the next frame. `mf_end` is checked after every frame, so a pulse that comes early, comes late or lasts two cycles is caught on the frame where it appears.

// File: rtl/crc4_mf_pkg.sv
package crc4_mf_pkg;
    typedef enum logic [1:0] {
        MF_HUNT    = 2'd0,
        MF_CONFIRM = 2'd1,
        MF_LOCKED  = 2'd2
    } mf_state_t;
endpackage

// File: rtl/crc4_mf_align.sv
module crc4_mf_align
    import crc4_mf_pkg::*;
#(
    parameter int WORD_LEN = 6,
    parameter logic [WORD_LEN-1:0] ALIGN_WORD = 6'b001011,
    parameter int MF_LEN = 16,
    parameter int WORD_END = 11,
    localparam int FW = $clog2(MF_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          nfas_phase,
    input  logic          ts0_b1,
    input  logic          bfa_lost,
    output logic          locked,
    output logic [FW-1:0] frame_num,
    output logic          frame_valid
);
    localparam logic [FW-1:0] LAST_F = FW'(MF_LEN - 1);
    localparam logic [FW-1:0] END_F  = FW'(WORD_END);

    mf_state_t state_q, state_d;
    logic [WORD_LEN-1:0] word_q, word_d;
    logic [FW-1:0] frame_q;
    logic hit, at_end;

    // window of the last odd-frame bits
    always_comb begin
        word_d = word_q;
        if (frame_stb && nfas_phase)
            word_d = {word_q[WORD_LEN-2:0], ts0_b1};
        hit = frame_stb && nfas_phase && (word_d == ALIGN_WORD);
    end

    // number of the frame being strobed now
    always_comb begin
        if (state_q == MF_HUNT)
            frame_num = END_F;
        else if (frame_q == LAST_F)
            frame_num = '0;
        else
            frame_num = frame_q + 1'b1;
        at_end = (frame_num == END_F);
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (bfa_lost) begin
            state_d = MF_HUNT;
        end else begin
            unique case (state_q)
                MF_HUNT:    if (hit) state_d = MF_CONFIRM;
                MF_CONFIRM: if (frame_stb && at_end)
                                state_d = hit ? MF_LOCKED : MF_HUNT;
                MF_LOCKED:  state_d = MF_LOCKED;
                default:    state_d = MF_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MF_HUNT;
            word_q  <= '0;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            if (frame_stb && (state_q != MF_HUNT || hit))
                frame_q <= frame_num;
        end
    end

    // outputs
    always_comb begin
        locked      = (state_q == MF_LOCKED);
        frame_valid = frame_stb && (state_q == MF_LOCKED) && !bfa_lost;
    end

    // R4
    bsync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bfa_lost |=> (state_q == MF_HUNT));

    // R2
    lock_at_word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !$past(locked)) |-> (frame_q == END_F && $past(frame_stb)));

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !bfa_lost) |=> locked);
endmodule

// File: rtl/crc4_ebit_track.sv
module crc4_ebit_track #(
    parameter int MF_LEN = 16,
    parameter int E1_FRAME = 13,
    parameter int E2_FRAME = 15,
    localparam int FW = $clog2(MF_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          locked,
    input  logic          frame_valid,
    input  logic [FW-1:0] frame_num,
    input  logic          ts0_b1,
    input  logic          rai_a,
    output logic          reb1_q,
    output logic          reb2_q,
    output logic          rcrcr_q,
    output logic          mf_pulse
);
    localparam logic [FW-1:0] E1_F   = FW'(E1_FRAME);
    localparam logic [FW-1:0] E2_F   = FW'(E2_FRAME);
    localparam logic [FW-1:0] LAST_F = FW'(MF_LEN - 1);

    logic e1_now, e2_now;

    always_comb begin
        e1_now = (frame_num == E1_F) ? ts0_b1 : reb1_q;
        e2_now = (frame_num == E2_F) ? ts0_b1 : reb2_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reb1_q   <= 1'b1;
            reb2_q   <= 1'b1;
            rcrcr_q  <= 1'b0;
            mf_pulse <= 1'b0;
        end else begin
            mf_pulse <= 1'b0;
            if (!locked) begin
                reb1_q  <= 1'b1;
                reb2_q  <= 1'b1;
                rcrcr_q <= 1'b0;
            end else if (frame_valid) begin
                reb1_q <= e1_now;
                reb2_q <= e2_now;
                if (frame_num == LAST_F) begin
                    rcrcr_q  <= rai_a & ~(e1_now & e2_now);
                    mf_pulse <= 1'b1;
                end
            end
        end
    end

    // R8
    mf_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse |=> !mf_pulse);

    // R7
    rcrcr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rcrcr_q) |-> ($past(frame_valid && frame_num == LAST_F) || $past(!locked)));
endmodule

// File: rtl/crc4_mf_tracker.sv
module crc4_mf_tracker #(
    parameter int WORD_LEN = 6,
    parameter logic [WORD_LEN-1:0] ALIGN_WORD = 6'b001011,
    parameter int MF_LEN = 16,
    parameter int WORD_END = 11,
    parameter int E1_FRAME = 13,
    parameter int E2_FRAME = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic nfas_phase,
    input  logic ts0_b1,
    input  logic rai_a,
    input  logic bfa_lost,
    output logic mfa_lost,
    output logic e1_stat,
    output logic e2_stat,
    output logic rem_crc_rai,
    output logic mf_end
);
    localparam int FW = $clog2(MF_LEN);

    logic          locked, frame_valid;
    logic [FW-1:0] frame_num;
    logic          reb1_q, reb2_q, rcrcr_q, mf_pulse;

    crc4_mf_align #(
        .WORD_LEN(WORD_LEN), .ALIGN_WORD(ALIGN_WORD),
        .MF_LEN(MF_LEN), .WORD_END(WORD_END)
    ) u_align (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .nfas_phase(nfas_phase), .ts0_b1(ts0_b1), .bfa_lost(bfa_lost),
        .locked(locked), .frame_num(frame_num), .frame_valid(frame_valid)
    );

    crc4_ebit_track #(
        .MF_LEN(MF_LEN), .E1_FRAME(E1_FRAME), .E2_FRAME(E2_FRAME)
    ) u_ebit (
        .clk(clk), .rst_n(rst_n), .locked(locked), .frame_valid(frame_valid),
        .frame_num(frame_num), .ts0_b1(ts0_b1), .rai_a(rai_a),
        .reb1_q(reb1_q), .reb2_q(reb2_q), .rcrcr_q(rcrcr_q), .mf_pulse(mf_pulse)
    );

    always_comb begin
        mfa_lost    = bfa_lost | ~locked;
        e1_stat     = mfa_lost | reb1_q;
        e2_stat     = mfa_lost | reb2_q;
        rem_crc_rai = ~mfa_lost & rcrcr_q;
        mf_end      = mf_pulse;
    end

    // R8
    mf_end_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mf_end |-> $past(locked));
endmodule

// File: tb/test_crc4_mf_tracker.sv
module test_crc4_mf_tracker;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [5:0] WORD = 6'b001011;
    // {e1, e2, a, expected rem_crc_rai}
    localparam logic [3:0] VEC [5] = '{4'b1110, 4'b0111, 4'b1011, 4'b0000, 4'b0011};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0, nfas_phase = 1'b0, ts0_b1 = 1'b0, rai_a = 1'b0, bfa_lost = 1'b0;
    logic mfa_lost, e1_stat, e2_stat, rem_crc_rai, mf_end;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc4_mf_tracker i_crc4_mf_tracker (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .nfas_phase(nfas_phase),
        .ts0_b1(ts0_b1), .rai_a(rai_a), .bfa_lost(bfa_lost),
        .mfa_lost(mfa_lost), .e1_stat(e1_stat), .e2_stat(e2_stat),
        .rem_crc_rai(rem_crc_rai), .mf_end(mf_end)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic send_frames(input int first, input int last, input bit e1, input bit e2,
                               input bit a, input bit bs, input bit bad, input bit exp_lock);
        for (int f = first; f <= last; f++) begin
            bit b;
            if (f % 2 == 0)      b = 1'b1;
            else if (f <= 11)    b = WORD[5 - (f - 1) / 2];
            else if (f == 13)    b = e1;
            else                 b = e2;
            if (bad && f == 5)   b = 1'b0;
            @(negedge clk);
            frame_stb  = 1'b1;
            nfas_phase = (f % 2 == 1);
            ts0_b1     = b;
            rai_a      = a;
            bfa_lost   = bs;
            @(negedge clk);
            frame_stb = 1'b0;
            // R8 / R9: pulse only after frame 15 of a locked multiframe
            check(mf_end, exp_lock && f == 15, $sformatf("R8 R9 mf_end frame %0d", f));
        end
    endtask

    task automatic send_mf(input bit e1, input bit e2, input bit a, input bit bs,
                           input bit bad, input bit exp_lock);
        send_frames(0, 15, e1, e2, a, bs, bad, exp_lock);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mfa_lost, 1'b1, "R1 mfa_lost");
        check(e1_stat, 1'b1, "R1 e1_stat");
        check(e2_stat, 1'b1, "R1 e2_stat");
        check(rem_crc_rai, 1'b0, "R1 rem_crc_rai");
        check(mf_end, 1'b0, "R1 mf_end");

        // first word: not yet synced, E-bits forced
        send_mf(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check(mfa_lost, 1'b1, "R2 one word only");
        check(e1_stat, 1'b1, "R6 e1 forced");
        check(e2_stat, 1'b1, "R6 e2 forced");
        check(rem_crc_rai, 1'b0, "R7 zero unsynced");

        // second word locks at frame 11
        send_frames(0, 11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check(mfa_lost, 1'b0, "R2 lock after frame 11");
        send_frames(12, 15, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check(e1_stat, 1'b0, "R5 e1 frame 13");
        check(e2_stat, 1'b0, "R5 e2 frame 15");
        check(rem_crc_rai, 1'b1, "R7 first multiframe");
        @(negedge clk);
        check(mf_end, 1'b0, "R8 pulse one cycle");

        // table walk
        for (int i = 0; i < 5; i++) begin
            send_mf(VEC[i][3], VEC[i][2], VEC[i][1], 1'b0, 1'b0, 1'b1);
            check(mfa_lost, 1'b0, $sformatf("R9 sync kept vec %0d", i));
            check(e1_stat, VEC[i][3], $sformatf("R5 e1 vec %0d", i));
            check(e2_stat, VEC[i][2], $sformatf("R5 e2 vec %0d", i));
            check(rem_crc_rai, VEC[i][0], $sformatf("R7 vec %0d", i));
        end

        // R7 holds mid-multiframe, R5 E1 updates at frame 13
        send_frames(0, 13, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check(e1_stat, 1'b1, "R5 e1 mid multiframe");
        check(e2_stat, 1'b0, "R5 e2 held until frame 15");
        check(rem_crc_rai, 1'b1, "R7 held mid multiframe");
        send_frames(14, 15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check(rem_crc_rai, 1'b0, "R7 updated at frame 15");

        // R4 alignment lost
        send_frames(0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check(mfa_lost, 1'b1, "R4 immediate");
        send_frames(1, 15, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check(mfa_lost, 1'b1, "R4 during loss");
        check(e1_stat, 1'b1, "R6 e1 during loss");
        check(rem_crc_rai, 1'b0, "R7 during loss");
        send_mf(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(mfa_lost, 1'b1, "R4 one word after loss");
        send_mf(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check(mfa_lost, 1'b0, "R4 relock");

        // R3 failed confirm
        send_mf(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        send_mf(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(mfa_lost, 1'b1, "R3 confirming");
        send_mf(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check(mfa_lost, 1'b1, "R3 bad word");
        send_mf(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(mfa_lost, 1'b1, "R3 search restarted");
        send_mf(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check(mfa_lost, 1'b0, "R3 relock");
        check(rem_crc_rai, 1'b1, "R7 after relock");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule